// File: doc/BRIEF.md
# Synchronous Multi-Channel DAC Serial Sequencer

This block feeds a serial multi-channel DAC. Four channels act as waveform outputs that must change at the same instant. Each accepted sample set goes out as one chip-select frame. The frame holds the register address of the first waveform channel, followed by the four sample words, and the device steps through the following channel registers by itself. When the frame ends, the block pulses the active-low load strobe so that all four outputs change together. Between sample bursts, one pending single-channel write to a utility channel can be sent as its own short frame.

The device needs a guard interval after every latch event before any chip select may fall again. For a burst, the latch event is the falling edge of the load strobe. For a utility write, it is the rising edge of chip select. The block holds that interval in every case and stretches the sample period when it has to. A sample-start pulse that arrives while the block cannot launch at once sets a sticky overrun flag. The samples are kept in a one-deep pending slot and are sent as soon as the guard allows.

The controller has five states: IDLE, BURST (shifting the streamed frame), GAP (chip select high before the strobe), LATCH (strobe low) and UTIL (shifting a utility frame). Its transitions are:
- IDLE to BURST on launch of a pending sample.
- IDLE to UTIL on launch of a pending utility write.
- BURST to GAP at the last bit.
- GAP to LATCH after the CS-to-strobe delay.
- LATCH to IDLE after the strobe width.
- UTIL to IDLE at the last bit.

Top module: `dac_burst_sequencer`

## Requirements
- R1: While reset is asserted and right after it, cs_n=1, ldac_n=1, sclk=0, mosi=0 and overrun=0.
- R2: A burst holds cs_n low for exactly 2×72 clock cycles and carries 72 bits MSB first. The first 8 bits are the stream address (default 0x14). Then come samples[0], samples[1], samples[2] and samples[3], each 16 bits.
- R3: SPI mode 1 framing applies. sclk is low whenever cs_n is high. Each bit lasts two clocks, with sclk high in the first and low in the second. mosi changes only together with a rising sclk.
- R4: ldac_n falls exactly CS2LD_CYC (2) cycles after cs_n rises at the end of a burst and stays low for exactly LDAC_CYC (2) cycles. It is never low while cs_n is low.
- R5: No cs_n falling edge comes earlier than GUARD_CYC (240) cycles after the last latch event. The latch event is the ldac_n falling edge for a burst and the cs_n rising edge for a utility write. When work is pending, cs_n falls exactly GUARD_CYC cycles after the latch event.
- R6: A utility write holds cs_n low for exactly 2×24 cycles and carries util_addr (8 bits) then util_data (16 bits), MSB first. No ldac_n pulse follows it.
- R7: A util_req that arrives while an earlier utility write is still pending replaces it. Only the latest address and data are sent.
- R8: When both kinds of work are pending at a launch point, a utility write goes first if a burst has been launched since the last utility write. Otherwise the samples go first.
- R9: A sample_start that arrives while the block is not idle, the guard is running, or samples are already pending sets overrun. overrun then stays set until reset. The newest samples are kept and sent later.
- R10: A sample_start accepted while the block is idle with the guard expired and nothing pending makes cs_n fall on the second rising clock edge after the pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_start | input | 1 | One-cycle pulse: capture samples and request a burst |
| samples | input | N_CH×DATA_W (64) | Four waveform samples, element 0 sent first |
| util_req | input | 1 | One-cycle pulse: capture a utility write |
| util_addr | input | ADDR_W (8) | Register address of the utility channel |
| util_data | input | DATA_W (16) | Utility channel data word |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data, MSB first |
| cs_n | output | 1 | Active-low chip select |
| ldac_n | output | 1 | Active-low synchronous load strobe |
| overrun | output | 1 | Sticky flag for a sample request that could not launch at once |

## Verification
A sample_start or util_req is captured on the next rising edge. overrun shows the result one edge after the pulse. A launch from idle drops cs_n one further edge later, together with the first sclk rise. ldac_n falls 144+CS2LD_CYC edges after cs_n falls. The next frame can start no sooner than GUARD_CYC edges after the latch event.

A behavioural model in the bench works out these instants from the requirements. Each rising edge, it pushes the expected value of every output for the coming cycle into a queue. All outputs are compared on the following falling edge, so every register stage has settled. A separate port monitor measures the distance from each latch event to the next chip-select fall.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BURST,
        ST_GAP,
        ST_LATCH,
        ST_UTIL
    } seq_state_t;

endpackage

// File: rtl/dacseq_guard.sv
module dacseq_guard #(
    parameter int GUARD_CYC = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(GUARD_CYC + 1);

    logic [CW-1:0] remain;

    // restart is raised in the cycle before the latch event, so the
    // count reaches zero GUARD_CYC-1 cycles after that event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (restart) begin
            remain <= CW'(GUARD_CYC - 1);
        end else if (remain != '0) begin
            remain <= remain - CW'(1);
        end
    end

    assign expired = (remain == '0);

    generate
        if (GUARD_CYC > 1) begin : g_chk
            AST_GUARD_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !expired); // R5
        end
    endgenerate

endmodule

// File: rtl/dacseq_shifter.sv
module dacseq_shifter #(
    parameter int FRAME_W = 72
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [FRAME_W-1:0]         frame,
    input  logic [$clog2(FRAME_W+1)-1:0] nbits,
    output logic                       sclk,
    output logic                       mosi,
    output logic                       done
);
    localparam int BW = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] sh;
    logic [BW-1:0]      left;
    logic               phase;
    logic               active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            left   <= '0;
            phase  <= 1'b0;
            active <= 1'b0;
        end else if (load) begin
            sh     <= frame;
            left   <= nbits;
            phase  <= 1'b0;
            active <= (nbits != '0);
        end else if (active) begin
            if (phase) begin
                sh    <= sh << 1;
                left  <= left - BW'(1);
                phase <= 1'b0;
                if (left == BW'(1)) begin
                    active <= 1'b0;
                end
            end else begin
                phase <= 1'b1;
            end
        end
    end

    // first half of a bit: clock high with new data, second half: clock low
    assign sclk = active & ~phase;
    assign mosi = active & sh[FRAME_W-1];
    assign done = active & phase & (left == BW'(1));

    AST_MOSI_HELD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(mosi)); // R3

endmodule

// File: rtl/dac_burst_sequencer.sv
module dac_burst_sequencer #(
    parameter int              DATA_W      = 16,
    parameter int              ADDR_W      = 8,
    parameter int              N_CH        = 4,
    parameter logic [ADDR_W-1:0] STREAM_ADDR = 8'h14,
    parameter int              CS2LD_CYC   = 2,
    parameter int              LDAC_CYC    = 2,
    parameter int              GUARD_CYC   = 240
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_start,
    input  logic [N_CH-1:0][DATA_W-1:0]  samples,
    input  logic                         util_req,
    input  logic [ADDR_W-1:0]            util_addr,
    input  logic [DATA_W-1:0]            util_data,
    output logic                         sclk,
    output logic                         mosi,
    output logic                         cs_n,
    output logic                         ldac_n,
    output logic                         overrun
);
    import dacseq_pkg::*;

    localparam int BURST_W = ADDR_W + N_CH * DATA_W;
    localparam int UTIL_W  = ADDR_W + DATA_W;
    localparam int BW      = $clog2(BURST_W + 1);
    localparam int TMAX    = (CS2LD_CYC > LDAC_CYC) ? CS2LD_CYC : LDAC_CYC;
    localparam int TW      = $clog2(TMAX + 1);

    seq_state_t state, state_n;
    logic [TW-1:0] tcnt;

    logic                        smp_pend;
    logic [N_CH-1:0][DATA_W-1:0] smp_q;
    logic                        util_pend;
    logic [ADDR_W-1:0]           uaddr_q;
    logic [DATA_W-1:0]           udata_q;
    logic                        util_turn;
    logic                        ovr_q;

    logic               guard_expired;
    logic               guard_restart;
    logic               ready;
    logic               go_util;
    logic               go_burst;
    logic               shift_done;
    logic [BURST_W-1:0] burst_frame;
    logic [BURST_W-1:0] load_frame;
    logic [BW-1:0]      load_bits;

    // streamed frame: start address, then channel 0 .. N_CH-1
    assign burst_frame[BURST_W-1 -: ADDR_W] = STREAM_ADDR;
    genvar g;
    generate
        for (g = 0; g < N_CH; g++) begin : g_pack
            assign burst_frame[BURST_W-ADDR_W-1-g*DATA_W -: DATA_W] = smp_q[g];
        end
    endgenerate

    assign ready    = (state == ST_IDLE) && guard_expired;
    assign go_util  = ready && util_pend && (util_turn || !smp_pend);
    assign go_burst = ready && smp_pend && !go_util;

    assign load_frame = go_util ? {uaddr_q, udata_q, {(BURST_W-UTIL_W){1'b0}}}
                                : burst_frame;
    assign load_bits  = go_util ? BW'(UTIL_W) : BW'(BURST_W);

    assign guard_restart = ((state == ST_GAP) && (tcnt == TW'(CS2LD_CYC - 1)))
                         || ((state == ST_UTIL) && shift_done);

    dacseq_shifter #(.FRAME_W(BURST_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go_util | go_burst),
        .frame (load_frame),
        .nbits (load_bits),
        .sclk  (sclk),
        .mosi  (mosi),
        .done  (shift_done)
    );

    dacseq_guard #(.GUARD_CYC(GUARD_CYC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (guard_restart),
        .expired (guard_expired)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (go_burst) state_n = ST_BURST;
                      else if (go_util) state_n = ST_UTIL;
            ST_BURST: if (shift_done) state_n = ST_GAP;
            ST_GAP:   if (tcnt == TW'(CS2LD_CYC - 1)) state_n = ST_LATCH;
            ST_LATCH: if (tcnt == TW'(LDAC_CYC - 1)) state_n = ST_IDLE;
            ST_UTIL:  if (shift_done) state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // interval counter and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt      <= '0;
            smp_pend  <= 1'b0;
            smp_q     <= '0;
            util_pend <= 1'b0;
            uaddr_q   <= '0;
            udata_q   <= '0;
            util_turn <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            tcnt <= (state_n != state) ? '0 : tcnt + TW'(1);
            if (sample_start) begin
                smp_pend <= 1'b1;
                smp_q    <= samples;
                if (!(ready && !smp_pend)) ovr_q <= 1'b1;
            end else if (go_burst) begin
                smp_pend <= 1'b0;
            end
            if (util_req) begin
                util_pend <= 1'b1;
                uaddr_q   <= util_addr;
                udata_q   <= util_data;
            end else if (go_util) begin
                util_pend <= 1'b0;
            end
            if (go_burst)     util_turn <= 1'b1;
            else if (go_util) util_turn <= 1'b0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        cs_n   = 1'b1;
        ldac_n = 1'b1;
        unique case (state)
            ST_BURST, ST_UTIL: cs_n   = 1'b0;
            ST_LATCH:          ldac_n = 1'b0;
            default: ;
        endcase
    end

    assign overrun = ovr_q;

    // width monitor for the load strobe
    logic [TW:0] ld_low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ld_low_cnt <= '0;
        else if (!ldac_n) ld_low_cnt <= ld_low_cnt + (TW+1)'(1);
        else              ld_low_cnt <= '0;
    end

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk); // R3
    AST_NO_LDAC_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> ldac_n); // R4
    AST_LDAC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ldac_n) |-> (ld_low_cnt == (TW+1)'(LDAC_CYC))); // R4
    AST_CS_AFTER_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(guard_expired)); // R5
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R9

endmodule

// File: tb/dac_burst_sequencer_tb.sv
module dac_burst_sequencer_tb;

    localparam int DW    = 16;
    localparam int AW    = 8;
    localparam int NC    = 4;
    localparam int CS2LD = 2;
    localparam int LDW   = 2;
    localparam int G     = 240;
    localparam logic [7:0] SADDR = 8'h14;
    localparam int BURST_BITS = AW + NC * DW;
    localparam int UTIL_BITS  = AW + DW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                    rst_n;
    logic                    sample_start;
    logic [NC-1:0][DW-1:0]   samples;
    logic                    util_req;
    logic [AW-1:0]           util_addr;
    logic [DW-1:0]           util_data;
    logic                    sclk, mosi, cs_n, ldac_n, overrun;

    dac_burst_sequencer #(
        .DATA_W(DW), .ADDR_W(AW), .N_CH(NC), .STREAM_ADDR(SADDR),
        .CS2LD_CYC(CS2LD), .LDAC_CYC(LDW), .GUARD_CYC(G)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sample_start(sample_start), .samples(samples),
        .util_req(util_req), .util_addr(util_addr), .util_data(util_data),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .ldac_n(ldac_n), .overrun(overrun)
    );

    int checks = 0;
    int bad    = 0;

    task automatic fail_line(input string tag, input int act, input int expv);
        bad++;
        $display("FAIL %s actual=%0d expected=%0d time=%0t", tag, act, expv, $time);
    endtask

    // ---------------- reference model ----------------
    // entry: {busy, cs_n, ldac_n, sclk, mosi}
    localparam logic [4:0] IDLE_V = 5'b0_1_1_0_0;
    logic [4:0] exp_q[$];
    logic [4:0] exp_now;
    int  cyc;
    int  guard_ok;
    bit  cur_busy;
    bit  s_pend, u_pend, u_turn, m_ovr;
    logic [NC-1:0][DW-1:0] s_dat;
    logic [AW-1:0] u_a;
    logic [DW-1:0] u_d;

    task automatic queue_bits(input logic [BURST_BITS-1:0] fr, input int n);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back({1'b1, 1'b0, 1'b1, 1'b1, fr[BURST_BITS-1-i]});
            exp_q.push_back({1'b1, 1'b0, 1'b1, 1'b0, fr[BURST_BITS-1-i]});
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q.delete();
            exp_now  = IDLE_V;
            cyc      = 0;
            guard_ok = 0;
            cur_busy = 1'b0;
            s_pend   = 1'b0;
            u_pend   = 1'b0;
            u_turn   = 1'b0;
            m_ovr    = 1'b0;
            s_dat    = '0;
            u_a      = '0;
            u_d      = '0;
        end else begin : step
            bit rdy;
            bit s_pre;
            cyc++;
            rdy   = !cur_busy && (cyc >= guard_ok);
            s_pre = s_pend;
            if (rdy) begin
                if (u_pend && (u_turn || !s_pend)) begin
                    queue_bits({u_a, u_d, {(BURST_BITS-UTIL_BITS){1'b0}}}, UTIL_BITS);
                    guard_ok = cyc + 2 * UTIL_BITS + G;
                    u_pend = 1'b0;
                    u_turn = 1'b0;
                end else if (s_pend) begin
                    queue_bits({SADDR, s_dat[0], s_dat[1], s_dat[2], s_dat[3]}, BURST_BITS);
                    for (int k = 0; k < CS2LD; k++) exp_q.push_back(5'b1_1_1_0_0);
                    for (int k = 0; k < LDW; k++)   exp_q.push_back(5'b1_1_0_0_0);
                    guard_ok = cyc + 2 * BURST_BITS + CS2LD + G;
                    s_pend = 1'b0;
                    u_turn = 1'b1;
                end
            end
            if (sample_start) begin
                if (!(rdy && !s_pre)) m_ovr = 1'b1;
                s_pend = 1'b1;
                s_dat  = samples;
            end
            if (util_req) begin
                u_pend = 1'b1;
                u_a    = util_addr;
                u_d    = util_data;
            end
            exp_now  = (exp_q.size() > 0) ? exp_q.pop_front() : IDLE_V;
            cur_busy = exp_now[4];
        end
    end

    // ---------------- comparison and port monitor ----------------
    int  ncyc = 0;
    int  last_ev = -1;
    logic p_cs = 1'b1, p_ld = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            ncyc++;
            checks += 5;
            if (cs_n   !== exp_now[3]) fail_line("R2 R5 R6 R10 cs_n", cs_n, exp_now[3]);
            if (ldac_n !== exp_now[2]) fail_line("R4 ldac_n", ldac_n, exp_now[2]);
            if (sclk   !== exp_now[1]) fail_line("R3 sclk", sclk, exp_now[1]);
            if (mosi   !== exp_now[0]) fail_line("R2 R6 R7 R8 mosi", mosi, exp_now[0]);
            if (overrun !== m_ovr)     fail_line("R9 overrun", overrun, m_ovr);
            if (cs_n && !p_cs) last_ev = ncyc;
            if (!ldac_n && p_ld) last_ev = ncyc;
            if (!cs_n && p_cs && last_ev >= 0) begin
                checks++;
                if (ncyc - last_ev < G) fail_line("R5 guard spacing", ncyc - last_ev, G);
            end
            p_cs = cs_n;
            p_ld = ldac_n;
        end
    end

    // ---------------- stimulus ----------------
    task automatic put_sample(input logic [DW-1:0] a, b, c, d);
        @(negedge clk);
        samples[0] = a; samples[1] = b; samples[2] = c; samples[3] = d;
        sample_start = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
    endtask

    task automatic put_util(input logic [AW-1:0] ad, input logic [DW-1:0] dv);
        @(negedge clk);
        util_addr = ad; util_data = dv; util_req = 1'b1;
        @(negedge clk);
        util_req = 1'b0;
    endtask

    task automatic put_both(input logic [DW-1:0] a, input logic [AW-1:0] ad,
                            input logic [DW-1:0] dv);
        @(negedge clk);
        samples[0] = a; samples[1] = ~a; samples[2] = a ^ 16'h0F0F; samples[3] = 16'h8001;
        util_addr = ad; util_data = dv;
        sample_start = 1'b1;
        util_req = 1'b1;
        @(negedge clk);
        sample_start = 1'b0;
        util_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog: run did not complete, cycles=%0d expected<%0d", 100000, 100000);
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        sample_start = 1'b0;
        samples = '0;
        util_req = 1'b0;
        util_addr = '0;
        util_data = '0;
        repeat (4) @(negedge clk);
        // R1: outputs held at rest during reset
        checks++;
        if ({cs_n, ldac_n, sclk, mosi, overrun} !== 5'b11000)
            fail_line("R1 reset state", {cs_n, ldac_n, sclk, mosi, overrun}, 5'b11000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2 R4 R10: single burst from idle, then a utility write queued mid-burst (R6)
        put_sample(16'hA5C3, 16'h0001, 16'hFFFF, 16'h7E81);
        repeat (20) @(negedge clk);
        put_util(8'h15, 16'hBEEF);
        repeat (900) @(negedge clk);

        // R8: both arrive together, last launch was a utility write: samples first
        put_both(16'h1234, 8'h16, 16'hC0DE);
        repeat (1000) @(negedge clk);

        // R8: util pending after a burst goes before newer samples
        put_sample(16'h0F0F, 16'hF0F0, 16'h3C3C, 16'hC3C3);
        repeat (10) @(negedge clk);
        put_util(8'h17, 16'h5A5A);
        put_sample(16'h1111, 16'h2222, 16'h3333, 16'h4444);
        repeat (1300) @(negedge clk);

        // R9 R5: samples every 250 cycles, faster than the guard allows
        for (int k = 0; k < 5; k++) begin
            put_sample(16'(k * 16'h1357), 16'(k + 1), 16'hAAAA ^ 16'(k), 16'h8000 >> k);
            repeat (248) @(negedge clk);
        end
        repeat (1200) @(negedge clk);

        // R7: a second request replaces the pending one
        put_sample(16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D);
        repeat (5) @(negedge clk);
        put_util(8'h11, 16'h1111);
        put_util(8'h12, 16'h2222);
        repeat (1500) @(negedge clk);

        finish_run();
    end

endmodule